// File: doc/BRIEF.md
# Pipelined bfloat16 Multiplier

This block multiplies two bfloat16 numbers (1 sign bit, 8 exponent bits, 7 stored fraction bits) and returns their bfloat16 product. Each operand's significand gets its implicit leading one back, and the two 8-bit significands go through an unsigned integer multiplier. That multiplier uses radix-4 Booth recoding of the second significand into five signed partial products of the first. A tree of 4:2 and 3:2 compressor cells reduces the partial products to a sum/carry pair. A final carry-propagate adder then resolves the pair: plain full-adder cells handle its two lowest columns and a vector adder handles the remaining columns.

The pipeline has four register stages. Stage 1 captures the recoded partial products and the operand classification. Stage 2 captures the compressed sum/carry pair. Stage 3 captures the 16-bit significand product. Stage 4 captures the packed result. A new operand pair can enter on every clock. A last stage sets the sign, forms the exponent, normalises the product and truncates it. Subnormal inputs are treated as zero. Overflow saturates to infinity. Underflow flushes to zero. Any NaN result is a single canonical quiet NaN.

Top module: `bf16PipeMul`

## Requirements
- R1: A pair sampled with `inValid` high at a rising edge produces `outValid` high after the fourth rising edge counted from that one. Pairs presented on consecutive cycles, or with idle gaps between them, give exactly one result each, in input order.
- R2: While `rst` is high at a rising edge, all pipeline valid bits and the result register clear. Pairs still in flight are discarded and never show up on `outValid`.
- R3: For finite non-zero inputs, the result is formed as follows. The sign is the XOR of the input sign bits. The exponent is eA + eB − 127, plus 1 when the 16-bit significand product has its bit 15 set. The fraction is product bits 14..8 when bit 15 is set, otherwise product bits 13..7.
- R4: The fraction is truncated, never rounded. Discarded product bits never raise the result, even when they are at or above one half ulp.
- R5: An input whose exponent field (bits 14..7) is 0 counts as zero, whatever its fraction. If the other input is finite, the result is a zero carrying the XOR sign: {sign, 15'b0}.
- R6: When the exponent from R3 exceeds 254, the result is infinity with the XOR sign: {sign, 8'hFF, 7'h00}.
- R7: When the exponent from R3 falls below 1, the result is a zero with the XOR sign. The output never carries a zero exponent together with a non-zero fraction.
- R8: An infinite input (exponent 255, fraction 0) times a finite non-zero input gives infinity with the XOR sign.
- R9: When either input is a NaN (exponent 255, fraction not 0), or an infinity is multiplied by a zero, the result is the canonical quiet NaN 16'h7FC0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Operand pair on `opA`/`opB` is valid this cycle |
| opA | input | 16 | First bfloat16 operand |
| opB | input | 16 | Second bfloat16 operand, the one that is Booth-recoded |
| outValid | output | 1 | `prodOut` holds a new result this cycle |
| prodOut | output | 16 | bfloat16 product |

## Verification
The bench runs all 16384 significand pairs three times, each time with a different exponent pair:
- The first exponent pair leaves the result comfortably normal. This exposes any Booth digit with the wrong sign or any compressor column that drops a carry, because such an error changes the fraction.
- The second pair puts the unnormalised exponent at 0. The result is then zero or the smallest normal depending only on whether the product reaches 2.0, so a missed normalisation increment flips the result between zero and a normal number.
- The third pair puts the exponent at 254, where the same choice decides between the largest exponent and infinity.

The bench also exercises the following:
- It crosses exponent corner values, including 0, 1, 254 and 255, with several fractions and signs. This catches subnormals that are not flushed, infinity × zero that does not give NaN, and a NaN sign or payload that leaks through.
- It streams arbitrary bit patterns with idle bubbles between them, which catches valid bits slipping against the data.
- It pulses reset with pairs in flight, which catches results that are not dropped on reset.
- It checks many products whose discarded bits are at or above one half ulp; a rounding design would give the next value up on these.

// File: rtl/bf16MulPkg.sv
package bf16MulPkg;
  localparam int EXP_W      = 8;
  localparam int FRAC_W     = 7;
  localparam int WORD_W     = 1 + EXP_W + FRAC_W;
  localparam int SIG_W      = FRAC_W + 1;
  localparam int PROD_W     = 2 * SIG_W;
  localparam int NUM_PP     = SIG_W / 2 + 1;
  localparam int EXT_W      = EXP_W + 2;
  localparam int BIAS       = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_MAX    = (1 << EXP_W) - 1;
  localparam int PIPE_DEPTH = 4;

  localparam logic [WORD_W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  typedef enum logic [1:0] {
    CLS_NUM,
    CLS_ZERO,
    CLS_INF,
    CLS_NAN
  } resClass_t;

  // load strobes from control to datapath, one per register stage
  typedef struct packed {
    logic ld1;
    logic ld2;
    logic ld3;
    logic ld4;
  } stageStrobe_t;

  typedef struct packed {
    logic                    sign;
    resClass_t               cls;
    logic signed [EXT_W-1:0] expSum;
  } resMeta_t;

  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

  function automatic logic [PROD_W-1:0] csaSum(input logic [PROD_W-1:0] x,
                                               input logic [PROD_W-1:0] y,
                                               input logic [PROD_W-1:0] z);
    return x ^ y ^ z;
  endfunction

  function automatic logic [PROD_W-1:0] csaCarry(input logic [PROD_W-1:0] x,
                                                 input logic [PROD_W-1:0] y,
                                                 input logic [PROD_W-1:0] z);
    logic [PROD_W-1:0] m;
    m = (x & y) | (x & z) | (y & z);
    return {m[PROD_W-2:0], 1'b0};
  endfunction
endpackage

// File: rtl/bf16BoothRecoder.sv
module bf16BoothRecoder
  import bf16MulPkg::*;
(
  input  logic [SIG_W-1:0]               mcand,
  input  logic [SIG_W-1:0]               mplier,
  output logic [NUM_PP-1:0][PROD_W-1:0]  pp,
  output logic [PROD_W-1:0]              negVec
);
  localparam int BEXT_W = 2 * NUM_PP + 1;

  logic [BEXT_W-1:0] bExt;
  logic [NUM_PP-1:0] negBits;

  assign bExt = {{(BEXT_W - SIG_W - 1){1'b0}}, mplier, 1'b0};

  for (genvar i = 0; i < NUM_PP; i++) begin : g_digit
    logic [2:0]        grp;
    logic              selOne;
    logic              selTwo;
    logic [PROD_W-1:0] mag;
    logic [PROD_W-1:0] row;

    assign grp    = bExt[2*i+2 -: 3];
    assign selOne = grp[0] ^ grp[1];
    assign selTwo = (grp == 3'b011) || (grp == 3'b100);
    assign negBits[i] = grp[2] & ~(grp[1] & grp[0]);
    assign mag    = selTwo ? {{(PROD_W - SIG_W - 1){1'b0}}, mcand, 1'b0} :
                    selOne ? {{(PROD_W - SIG_W){1'b0}}, mcand} : '0;
    // one's complement here, the +1 of the negation goes into negVec
    assign row    = negBits[i] ? ~mag : mag;
    assign pp[i]  = row << (2 * i);
  end

  always_comb begin
    negVec = '0;
    for (int i = 0; i < NUM_PP; i++) begin
      negVec[2*i] = negBits[i];
    end
  end
endmodule

// File: rtl/bf16CompressTree.sv
module bf16CompressTree
  import bf16MulPkg::*;
(
  input  logic [NUM_PP-1:0][PROD_W-1:0] pp,
  input  logic [PROD_W-1:0]             negVec,
  output logic [PROD_W-1:0]             sumVec,
  output logic [PROD_W-1:0]             carryVec
);
  logic [PROD_W-1:0] s42;
  logic [PROD_W-1:0] c42;
  logic [PROD_W-1:0] chainIn;
  logic [PROD_W-1:0] s32;
  logic [PROD_W-1:0] c32;

  assign chainIn[0] = 1'b0;
  assign c42[0]     = 1'b0;

  // 4:2 compressor row over the first four partial products
  for (genvar k = 0; k < PROD_W; k++) begin : g_cmp42
    logic fs;
    assign fs     = pp[0][k] ^ pp[1][k] ^ pp[2][k];
    assign s42[k] = fs ^ pp[3][k] ^ chainIn[k];
    if (k < PROD_W - 1) begin : g_carry
      assign chainIn[k+1] = maj3(pp[0][k], pp[1][k], pp[2][k]);
      assign c42[k+1]     = maj3(fs, pp[3][k], chainIn[k]);
    end
  end

  // two 3:2 rows fold in the last partial product and the negation bits
  assign s32      = csaSum(pp[NUM_PP-1], negVec, s42);
  assign c32      = csaCarry(pp[NUM_PP-1], negVec, s42);
  assign sumVec   = csaSum(s32, c32, c42);
  assign carryVec = csaCarry(s32, c32, c42);
endmodule

// File: rtl/bf16FinalAdder.sv
module bf16FinalAdder
  import bf16MulPkg::*;
(
  input  logic [PROD_W-1:0] sumVec,
  input  logic [PROD_W-1:0] carryVec,
  output logic [PROD_W-1:0] prod
);
  logic c1;
  logic c2;

  assign prod[0] = sumVec[0] ^ carryVec[0];
  assign c1      = sumVec[0] & carryVec[0];
  assign prod[1] = sumVec[1] ^ carryVec[1] ^ c1;
  assign c2      = maj3(sumVec[1], carryVec[1], c1);
  assign prod[PROD_W-1:2] = sumVec[PROD_W-1:2] + carryVec[PROD_W-1:2]
                          + {{(PROD_W - 3){1'b0}}, c2};
endmodule

// File: rtl/bf16MulCtrl.sv
module bf16MulCtrl
  import bf16MulPkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  output stageStrobe_t stb,
  output logic         outValid
);
  logic [PIPE_DEPTH-1:0] vld;
  logic [2:0]            sinceRst;

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else     vld <= {vld[PIPE_DEPTH-2:0], inValid};
  end

  assign stb.ld1  = inValid;
  assign stb.ld2  = vld[0];
  assign stb.ld3  = vld[1];
  assign stb.ld4  = vld[2];
  assign outValid = vld[PIPE_DEPTH-1];

  always_ff @(posedge clk) begin
    if (rst)                 sinceRst <= '0;
    else if (sinceRst != '1) sinceRst <= sinceRst + 3'd1;
  end

  AST_LATENCY_FIXED: assert property (@(posedge clk) disable iff (rst)
    (sinceRst >= 3'(PIPE_DEPTH)) |-> (outValid == $past(inValid, PIPE_DEPTH)));  // R1
endmodule

// File: rtl/bf16MulDatapath.sv
module bf16MulDatapath
  import bf16MulPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  stageStrobe_t      stb,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  output logic [WORD_W-1:0] prodOut
);
  localparam logic signed [EXT_W-1:0] EXP_TOP = EXT_W'(EXP_MAX - 1);
  localparam logic signed [EXT_W-1:0] EXP_LOW = EXT_W'(1);

  // ---- stage 1: unpack, classify, recode
  logic [EXP_W-1:0]  expA, expB;
  logic [FRAC_W-1:0] fracA, fracB;
  logic              zeroA, zeroB, infA, infB, nanA, nanB;
  resMeta_t          metaIn;
  logic [NUM_PP-1:0][PROD_W-1:0] ppComb;
  logic [PROD_W-1:0] negComb;

  assign expA  = opA[WORD_W-2:FRAC_W];
  assign expB  = opB[WORD_W-2:FRAC_W];
  assign fracA = opA[FRAC_W-1:0];
  assign fracB = opB[FRAC_W-1:0];
  assign zeroA = (expA == '0);
  assign zeroB = (expB == '0);
  assign infA  = (expA == '1) && (fracA == '0);
  assign infB  = (expB == '1) && (fracB == '0);
  assign nanA  = (expA == '1) && (fracA != '0);
  assign nanB  = (expB == '1) && (fracB != '0);

  always_comb begin
    metaIn.sign   = opA[WORD_W-1] ^ opB[WORD_W-1];
    metaIn.expSum = EXT_W'(expA) + EXT_W'(expB) - EXT_W'(BIAS);
    if (nanA || nanB || (infA && zeroB) || (infB && zeroA)) metaIn.cls = CLS_NAN;
    else if (infA || infB)                                  metaIn.cls = CLS_INF;
    else if (zeroA || zeroB)                                metaIn.cls = CLS_ZERO;
    else                                                    metaIn.cls = CLS_NUM;
  end

  bf16BoothRecoder u_recoder (
    .mcand  ({1'b1, fracA}),
    .mplier ({1'b1, fracB}),
    .pp     (ppComb),
    .negVec (negComb)
  );

  logic [NUM_PP-1:0][PROD_W-1:0] ppS1;
  logic [PROD_W-1:0]             negS1;
  resMeta_t                      metaS1;

  always_ff @(posedge clk) begin
    if (stb.ld1) begin
      ppS1   <= ppComb;
      negS1  <= negComb;
      metaS1 <= metaIn;
    end
  end

  // ---- stage 2: compressor tree
  logic [PROD_W-1:0] sumComb, carryComb;
  logic [PROD_W-1:0] sumS2, carryS2;
  resMeta_t          metaS2;

  bf16CompressTree u_tree (
    .pp       (ppS1),
    .negVec   (negS1),
    .sumVec   (sumComb),
    .carryVec (carryComb)
  );

  always_ff @(posedge clk) begin
    if (stb.ld2) begin
      sumS2   <= sumComb;
      carryS2 <= carryComb;
      metaS2  <= metaS1;
    end
  end

  // ---- stage 3: carry-propagate addition
  logic [PROD_W-1:0] prodComb;
  logic [PROD_W-1:0] prodS3;
  resMeta_t          metaS3;

  bf16FinalAdder u_cpa (
    .sumVec   (sumS2),
    .carryVec (carryS2),
    .prod     (prodComb)
  );

  always_ff @(posedge clk) begin
    if (stb.ld3) begin
      prodS3 <= prodComb;
      metaS3 <= metaS2;
    end
  end

  // ---- stage 4: normalise, truncate, pack
  logic                    normUp;
  logic [FRAC_W-1:0]       fracN;
  logic signed [EXT_W-1:0] expFin;
  logic [WORD_W-1:0]       packed4;

  assign normUp = prodS3[PROD_W-1];
  assign fracN  = normUp ? prodS3[PROD_W-2 -: FRAC_W] : prodS3[PROD_W-3 -: FRAC_W];
  assign expFin = metaS3.expSum + EXT_W'(normUp);

  always_comb begin
    unique case (metaS3.cls)
      CLS_NAN:  packed4 = QNAN;
      CLS_INF:  packed4 = {metaS3.sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      CLS_ZERO: packed4 = {metaS3.sign, {(WORD_W-1){1'b0}}};
      default: begin
        if (expFin > EXP_TOP)      packed4 = {metaS3.sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        else if (expFin < EXP_LOW) packed4 = {metaS3.sign, {(WORD_W-1){1'b0}}};
        else                       packed4 = {metaS3.sign, expFin[EXP_W-1:0], fracN};
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          prodOut <= '0;
    else if (stb.ld4) prodOut <= packed4;
  end

  // both significands carry their leading one, so the product is >= 2^(PROD_W-2)
  AST_PROD_NORMALISED: assert property (@(posedge clk) disable iff (rst)
    stb.ld4 |-> (prodS3[PROD_W-1:PROD_W-2] != 2'b00));  // R3
endmodule

// File: rtl/bf16PipeMul.sv
module bf16PipeMul
  import bf16MulPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  output logic              outValid,
  output logic [WORD_W-1:0] prodOut
);
  stageStrobe_t stb;

  bf16MulCtrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .stb      (stb),
    .outValid (outValid)
  );

  bf16MulDatapath u_dp (
    .clk     (clk),
    .rst     (rst),
    .stb     (stb),
    .opA     (opA),
    .opB     (opB),
    .prodOut (prodOut)
  );

  AST_NAN_CANONICAL: assert property (@(posedge clk) disable iff (rst)
    (outValid && (prodOut[WORD_W-2:FRAC_W] == '1) && (prodOut[FRAC_W-1:0] != '0))
      |-> (prodOut == QNAN));  // R9

  AST_NO_SUBNORMAL: assert property (@(posedge clk) disable iff (rst)
    (outValid && (prodOut[WORD_W-2:FRAC_W] == '0)) |-> (prodOut[FRAC_W-1:0] == '0));  // R7
endmodule

// File: tb/bf16PipeMul_bench.sv
module bf16PipeMul_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [15:0] opA = '0;
  logic [15:0] opB = '0;
  logic        outValid;
  logic [15:0] prodOut;

  int nCompared = 0;
  int nMismatch = 0;
  bit finished = 0;

  logic [15:0] expQ[$];
  string       tagQ[$];
  logic [31:0] opQ[$];

  always #10 clk = ~clk;

  bf16PipeMul u_bf16PipeMul (
    .clk(clk), .rst(rst), .inValid(inValid), .opA(opA), .opB(opB),
    .outValid(outValid), .prodOut(prodOut)
  );

  function automatic logic [15:0] refMul(input logic [15:0] a, input logic [15:0] b,
                                         output string tag);
    logic s;
    int ea, eb, fa, fb, p, e, fr, dropped, half;
    logic za, zb, ia, ib, na, nb;
    s  = a[15] ^ b[15];
    ea = int'(a[14:7]); eb = int'(b[14:7]);
    fa = int'(a[6:0]);  fb = int'(b[6:0]);
    za = (ea == 0); zb = (eb == 0);
    ia = (ea == 255) && (fa == 0); ib = (eb == 255) && (fb == 0);
    na = (ea == 255) && (fa != 0); nb = (eb == 255) && (fb != 0);
    if (na || nb || (ia && zb) || (ib && za)) begin tag = "R9"; return 16'h7FC0; end
    if (ia || ib) begin tag = "R8"; return {s, 8'hFF, 7'h00}; end
    if (za || zb) begin tag = "R5"; return {s, 15'h0}; end
    p = (128 + fa) * (128 + fb);
    e = ea + eb - 127;
    if (p >= 32768) begin
      e = e + 1; fr = (p >> 8) & 127; dropped = p & 255; half = 128;
    end else begin
      fr = (p >> 7) & 127; dropped = p & 127; half = 64;
    end
    if (e > 254) begin tag = "R6"; return {s, 8'hFF, 7'h00}; end
    if (e < 1)   begin tag = "R7"; return {s, 15'h0}; end
    tag = (dropped >= half) ? "R4" : "R3";
    return {s, 8'(e), 7'(fr)};
  endfunction

  // scoreboard: compares every output against the queued expectation
  always @(negedge clk) begin
    if (!rst && outValid) begin
      nCompared++;
      if (expQ.size() == 0) begin
        nMismatch++;
        $display("FAIL R1 unexpected output: actual=%h expected=none", prodOut);
      end else begin
        logic [15:0] ev;
        string       tg;
        logic [31:0] ops;
        ev = expQ.pop_front(); tg = tagQ.pop_front(); ops = opQ.pop_front();
        if (prodOut !== ev) begin
          nMismatch++;
          if (nMismatch < 20)
            $display("FAIL %s a=%h b=%h actual=%h expected=%h", tg, ops[31:16], ops[15:0], prodOut, ev);
        end
      end
    end
  end

  task automatic sendOp(input logic [15:0] a, input logic [15:0] b);
    string tg;
    logic [15:0] ev;
    @(negedge clk);
    inValid = 1'b1; opA = a; opB = b;
    ev = refMul(a, b, tg);
    expQ.push_back(ev); tagQ.push_back(tg); opQ.push_back({a, b});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
    end
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    nCompared++;
    if (!ok) begin
      nMismatch++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic finishRun();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nMismatch++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      finishRun();
    end
  end

  initial begin
    int first;
    logic [15:0] lfsr;
    logic [15:0] cornerExp [12];
    logic [6:0]  cornerFrac [4];
    cornerExp  = '{16'd0, 16'd1, 16'd2, 16'd63, 16'd100, 16'd126,
                   16'd127, 16'd128, 16'd200, 16'd253, 16'd254, 16'd255};
    cornerFrac = '{7'h00, 7'h01, 7'h40, 7'h7F};

    // R2: reset state
    idle(3);
    @(negedge clk); rst = 1'b0;
    check(outValid == 1'b0, "R2 outValid after reset", int'(outValid), 0);
    check(prodOut == 16'h0, "R2 result after reset", int'(prodOut), 0);

    // R2: reset drops in-flight pairs
    sendOp(16'h3F80, 16'h4000);
    sendOp(16'h4040, 16'h4040);
    sendOp(16'hC000, 16'h3F00);
    @(negedge clk);
    inValid = 1'b0; rst = 1'b1;
    expQ.delete(); tagQ.delete(); opQ.delete();
    @(negedge clk); rst = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check(outValid == 1'b0, "R2 flushed pair appeared", int'(outValid), 0);
    end

    // R1: latency of a lone pair
    sendOp(16'h3FC0, 16'h3FC0);
    first = 0;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      inValid = 1'b0;
      if (outValid && first == 0) first = k;
    end
    check(first == 4, "R1 latency", first, 4);

    // R3/R4: exhaustive significands, normal range, back to back
    for (int fa = 0; fa < 128; fa++)
      for (int fb = 0; fb < 128; fb++)
        sendOp({1'(fa), 8'd127, 7'(fa)}, {1'(fb >> 1), 8'd127, 7'(fb)});
    // R7: unnormalised exponent 0, normalisation decides zero versus smallest normal
    for (int fa = 0; fa < 128; fa++)
      for (int fb = 0; fb < 128; fb++)
        sendOp({1'(fb), 8'd1, 7'(fa)}, {1'b0, 8'd126, 7'(fb)});
    // R6: unnormalised exponent 254, normalisation decides largest versus infinity
    for (int fa = 0; fa < 128; fa++)
      for (int fb = 0; fb < 128; fb++)
        sendOp({1'b0, 8'd200, 7'(fa)}, {1'(fa), 8'd181, 7'(fb)});
    idle(6);

    // R5/R8/R9/R6/R7: exponent corners
    for (int i = 0; i < 12; i++)
      for (int j = 0; j < 12; j++)
        for (int f = 0; f < 4; f++)
          for (int sg = 0; sg < 2; sg++)
            sendOp({1'(sg), 8'(cornerExp[i]), cornerFrac[f]},
                   {1'(f), 8'(cornerExp[j]), cornerFrac[(f + j) % 4]});
    idle(6);

    // R1: arbitrary patterns with bubbles
    lfsr = 16'hACE1;
    for (int n = 0; n < 4000; n++) begin
      logic [15:0] a;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = lfsr;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      sendOp(a, lfsr);
      if (lfsr[2:0] == 3'b000) idle(1 + int'(lfsr[4:3]));
    end
    idle(8);
    check(expQ.size() == 0, "R1 results outstanding after drain", expQ.size(), 0);

    finishRun();
  end
endmodule